// File: doc/BRIEF.md
# Memory Access Ordering Hold Matrix

This block tracks up to a parameterised number of in-flight memory operations and decides which of them must be held back so that loads and stores leave in a safe order. Every operation claims a slot when it issues and gives it up when it completes or is cancelled. At issue, the new operation's address is compared with the address of every live slot. The comparison uses only a narrow window of address bits, so it answers "could these two touch the same memory?" rather than "do they overlap exactly?". Any match within that window counts as a conflict.

The answers are stored in two per-pair bit matrices. One records which operations are older, the other records which pairs could conflict. From these the block drives a read hold and a write hold for every slot. The function-unit dependency matrix uses them to withhold the read grant of a load or the write grant of a store. A load waits on older stores that may conflict with it. A store waits on older loads and older stores that may conflict with it. Two loads never wait on each other.

Top module: `mem_hold_matrix`

## Requirements
- R1: After reset every slot is empty and both `rd_hold` and `wr_hold` are all zero.
- R2: The conflict test compares only byte-address bits [11:3] (8-byte granularity). Two addresses that differ only in bits [2:0] or only above bit 11 are treated as conflicting.
- R3: A store issued after a live load whose address may conflict has its `wr_hold` bit set, and never its `rd_hold` bit.
- R4: A load issued after a live store whose address may conflict has its `rd_hold` bit set, and never its `wr_hold` bit.
- R5: A load never holds another load, whatever their addresses.
- R6: A store issued after a live store whose address may conflict has its `wr_hold` bit set, so the two stores write in issue order.
- R7: Operations whose bits [11:3] differ never hold each other.
- R8: A `done_valid` pulse naming a live slot frees that slot from the next cycle. Every hold that slot caused is released. An operation issued in the same cycle is not held by the slot being freed.
- R9: Every live slot whose bit is set in `cancel_mask` is freed in the same cycle, and the holds it caused are released. Several slots can be freed at once.
- R10: An issue aimed at a slot that is already live is ignored. The slot keeps its type and address.
- R11: Holds follow issue order, not slot index. An older operation is never held by a younger one.
- R12: Holds are derived from registered state. An issue taken at a clock edge affects `rd_hold`/`wr_hold` right after that edge. A slot alone in the matrix is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A memory operation issues this cycle |
| issue_slot | input | SW | Slot index claimed by the issuing operation |
| issue_is_store | input | 1 | 1 = store, 0 = load |
| issue_addr | input | ADDR_W | Byte address of the issuing operation |
| done_valid | input | 1 | An operation completes this cycle |
| done_slot | input | SW | Slot index of the completing operation |
| cancel_mask | input | N_SLOTS | One bit per slot to drop on a mispredict |
| rd_hold | output | N_SLOTS | Per-slot hold on the read grant (loads) |
| wr_hold | output | N_SLOTS | Per-slot hold on the write grant (stores) |

## Verification
The bench sweeps every ordered pair of slots and every combination of load and store. For each, it uses addresses that match exactly, differ only below bit 3, differ only above bit 11, and differ in one bit inside the compared window. A design that compared the full address would miss the aliasing holds. One that compared too few bits would raise holds on disjoint accesses. One that used slot index instead of issue order would hold the older operation. One that treated load pairs as conflicts would stall independent loads.

Separate sequences check the rest. One cancels several slots at once and expects a partially released store. One re-issues into a busy slot, where a design that overwrote it would lose the original store. One frees a slot in the same cycle a dependent issues, where a design that compared against the dying slot would leave a stale hold.

// File: rtl/mhm_pkg.sv
package mhm_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_op_e;

    // A pair needs ordering unless both sides are loads.
    function automatic logic needs_order(input logic older_is_st,
                                         input logic younger_is_st);
        return older_is_st | younger_is_st;
    endfunction

endpackage

// File: rtl/mhm_addr_cmp.sv
module mhm_addr_cmp #(
    parameter int N_SLOTS = 4,
    parameter int PW      = 9
) (
    input  logic [PW-1:0]               probe,
    input  logic [N_SLOTS-1:0][PW-1:0]  held,
    output logic [N_SLOTS-1:0]          hit
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign hit[g] = (held[g] == probe);
    end

endmodule

// File: rtl/mhm_hold_reduce.sv
module mhm_hold_reduce #(
    parameter int N_SLOTS = 4
) (
    input  logic [N_SLOTS-1:0]              live,
    input  logic [N_SLOTS-1:0]              is_st,
    input  logic [N_SLOTS-1:0][N_SLOTS-1:0] blk,
    output logic [N_SLOTS-1:0]              rd_hold,
    output logic [N_SLOTS-1:0]              wr_hold
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_row
        logic [N_SLOTS-1:0] eff;
        assign eff        = blk[g] & live;
        assign rd_hold[g] = live[g] & ~is_st[g] & (|(eff & is_st));
        assign wr_hold[g] = live[g] &  is_st[g] & (|eff);
    end

endmodule

// File: rtl/mem_hold_matrix.sv
module mem_hold_matrix
    import mhm_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 32,
    parameter int PA_LSB  = 3,
    parameter int PA_MSB  = 11,
    localparam int SW     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [SW-1:0]      issue_slot,
    input  logic               issue_is_store,
    input  logic [ADDR_W-1:0]  issue_addr,
    input  logic               done_valid,
    input  logic [SW-1:0]      done_slot,
    input  logic [N_SLOTS-1:0] cancel_mask,
    output logic [N_SLOTS-1:0] rd_hold,
    output logic [N_SLOTS-1:0] wr_hold
);

    localparam int PW = PA_MSB - PA_LSB + 1;

    typedef struct packed {
        logic [N_SLOTS-1:0]              live;
        logic [N_SLOTS-1:0]              is_st;
        logic [N_SLOTS-1:0][PW-1:0]      paddr;
        logic [N_SLOTS-1:0][N_SLOTS-1:0] age;   // age[i][j]: j issued before i
        logic [N_SLOTS-1:0][N_SLOTS-1:0] conf;  // conf[i][j]: i may clash with j
    } state_t;

    state_t state_q, state_d;

    logic [PW-1:0]                   probe;
    logic [N_SLOTS-1:0]              hit;
    logic [N_SLOTS-1:0]              free_vec;
    logic [N_SLOTS-1:0]              survive;
    logic                            accept;
    logic [N_SLOTS-1:0][N_SLOTS-1:0] blk;
    logic [N_SLOTS-1:0]              live_q;

    assign probe  = issue_addr[PA_MSB:PA_LSB];
    assign live_q = state_q.live;

    mhm_addr_cmp #(.N_SLOTS(N_SLOTS), .PW(PW)) u_cmp (
        .probe (probe),
        .held  (state_q.paddr),
        .hit   (hit)
    );

    always_comb begin
        for (int j = 0; j < N_SLOTS; j++) begin
            free_vec[j] = cancel_mask[j] | (done_valid && (done_slot == SW'(j)));
        end
        survive = state_q.live & ~free_vec;
        accept  = issue_valid && !state_q.live[issue_slot];

        state_d      = state_q;
        state_d.live = survive;

        for (int i = 0; i < N_SLOTS; i++) begin
            for (int j = 0; j < N_SLOTS; j++) begin
                if (free_vec[i] || free_vec[j]) begin
                    state_d.age[i][j]  = 1'b0;
                    state_d.conf[i][j] = 1'b0;
                end
            end
        end

        if (accept) begin
            state_d.live[issue_slot]  = 1'b1;
            state_d.is_st[issue_slot] = issue_is_store;
            state_d.paddr[issue_slot] = probe;
            for (int j = 0; j < N_SLOTS; j++) begin
                state_d.age[j][issue_slot]  = 1'b0;
                state_d.conf[j][issue_slot] = 1'b0;
                if (issue_slot == SW'(j)) begin
                    state_d.age[issue_slot][j]  = 1'b0;
                    state_d.conf[issue_slot][j] = 1'b0;
                end else begin
                    state_d.age[issue_slot][j]  = survive[j];
                    state_d.conf[issue_slot][j] = survive[j] && hit[j] &&
                        needs_order(state_q.is_st[j], issue_is_store);
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            blk[i] = state_q.age[i] & state_q.conf[i];
        end
    end

    mhm_hold_reduce #(.N_SLOTS(N_SLOTS)) u_reduce (
        .live    (state_q.live),
        .is_st   (state_q.is_st),
        .blk     (blk),
        .rd_hold (rd_hold),
        .wr_hold (wr_hold)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/mhm_matrix_checker.sv
module mhm_matrix_checker #(
    parameter int N_SLOTS = 4,
    parameter int SW      = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic [SW-1:0]      issue_slot,
    input logic               done_valid,
    input logic [SW-1:0]      done_slot,
    input logic [N_SLOTS-1:0] cancel_mask,
    input logic [N_SLOTS-1:0] live_q,
    input logic [N_SLOTS-1:0] rd_hold,
    input logic [N_SLOTS-1:0] wr_hold
);

    // R1: no hold on an empty slot
    a_r1_hold_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hold | wr_hold) & ~live_q) == '0);

    // R3/R4: a slot is held on read or on write, never both
    a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold & wr_hold) == '0);

    // R8: completion of a live slot releases it
    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && live_q[done_slot]) |=>
            (!rd_hold[$past(done_slot)] && !wr_hold[$past(done_slot)]
             && !live_q[$past(done_slot)]));

    // R9: cancelled live slots are gone next cycle
    a_r9_cancel_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cancel_mask & live_q)) |=> ((live_q & $past(cancel_mask & live_q)) == '0));

    // R10: an issue into a busy slot leaves it live
    a_r10_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && live_q[issue_slot] && !cancel_mask[issue_slot]
         && !(done_valid && done_slot == issue_slot)) |=> live_q[$past(issue_slot)]);

endmodule

bind mem_hold_matrix mhm_matrix_checker #(.N_SLOTS(N_SLOTS), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_slot  (issue_slot),
    .done_valid  (done_valid),
    .done_slot   (done_slot),
    .cancel_mask (cancel_mask),
    .live_q      (live_q),
    .rd_hold     (rd_hold),
    .wr_hold     (wr_hold)
);

// File: tb/mem_hold_matrix_bench.sv
module mem_hold_matrix_bench;

    localparam int N  = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [SW-1:0] issue_slot = '0;
    logic          issue_is_store = 1'b0;
    logic [31:0]   issue_addr = '0;
    logic          done_valid = 1'b0;
    logic [SW-1:0] done_slot = '0;
    logic [N-1:0]  cancel_mask = '0;
    logic [N-1:0]  rd_hold, wr_hold;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mem_hold_matrix u_mem_hold_matrix (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_slot(issue_slot),
        .issue_is_store(issue_is_store), .issue_addr(issue_addr),
        .done_valid(done_valid), .done_slot(done_slot), .cancel_mask(cancel_mask),
        .rd_hold(rd_hold), .wr_hold(wr_hold)
    );

    task automatic check(input string tag, input logic [N-1:0] exp_rd, input logic [N-1:0] exp_wr);
        n_chk++;
        if (rd_hold !== exp_rd || wr_hold !== exp_wr) begin
            n_fail++;
            $display("FAIL %s: rd_hold=%b exp %b, wr_hold=%b exp %b", tag, rd_hold, exp_rd, wr_hold, exp_wr);
        end
    endtask

    task automatic issue(input int slot, input bit st, input logic [31:0] addr);
        issue_valid = 1'b1; issue_slot = SW'(slot); issue_is_store = st; issue_addr = addr;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic finish_op(input int slot);
        done_valid = 1'b1; done_slot = SW'(slot);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic cancel(input logic [N-1:0] m);
        cancel_mask = m;
        @(negedge clk);
        cancel_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", '0, '0);

        // Pair sweep: R2..R7, R8, R11, R12
        for (int ko = 0; ko < 2; ko++)
        for (int ky = 0; ky < 2; ky++)
        for (int o = 0; o < N; o++)
        for (int y = 0; y < N; y++)
        for (int v = 0; v < 4; v++) begin
            logic [31:0] a, b;
            bit conf;
            logic [N-1:0] er, ew;
            string tag;
            if (y == o) continue;
            a = 32'h3C8 + 32'(o * 72 + y * 264 + v * 40 + ko * 1024 + ky * 4096);
            case (v)
                0: b = a;
                1: b = a ^ 32'h5;
                2: b = a ^ (32'h1000 << y);
                default: b = a ^ (32'h8 << ((o * 4 + y) % 9));
            endcase
            conf = (((a ^ b) >> 3) & 32'h1FF) == 0;
            er = '0; ew = '0;
            if (conf && ky == 1) ew[y] = 1'b1;
            if (conf && ky == 0 && ko == 1) er[y] = 1'b1;
            if (!conf)                 tag = "R7";
            else if (ko == 0 && ky == 0) tag = "R5";
            else if (ko == 0)          tag = "R3";
            else if (ky == 1)          tag = "R6";
            else                       tag = "R4";
            if (v == 1 || v == 2) tag = {tag, "/R2"};

            issue(o, ko[0], a);
            check("R12 single op", '0, '0);
            issue(y, ky[0], b);
            check({tag, "/R11"}, er, ew);
            finish_op(o);
            check("R8 older done", '0, '0);
            finish_op(y);
            check("R8 drained", '0, '0);
        end

        // R9: store0, load1, load2, store3 at one address
        issue(0, 1'b1, 32'h800);
        issue(1, 1'b0, 32'h804);
        issue(2, 1'b0, 32'h2800);
        issue(3, 1'b1, 32'h807);
        check("R9 setup", 4'b0110, 4'b1000);
        cancel(4'b0001);
        check("R9 partial cancel", 4'b0000, 4'b1000);
        cancel(4'b0110);
        check("R9 multi cancel", 4'b0000, 4'b0000);
        cancel(4'b1000);
        check("R9 empty", '0, '0);

        // R10: re-issue into busy slot is ignored
        issue(0, 1'b1, 32'h100);
        issue(0, 1'b0, 32'h300);
        check("R10 ignored issue", '0, '0);
        issue(1, 1'b0, 32'h100);
        check("R10 slot kept store", 4'b0010, 4'b0000);
        issue(2, 1'b0, 32'h300);
        check("R10 address kept", 4'b0010, 4'b0000);
        cancel(4'b0111);
        check("R10 cleared", '0, '0);

        // R8: free and dependent issue in the same cycle
        issue(0, 1'b1, 32'h40);
        done_valid = 1'b1; done_slot = 2'd0;
        issue(1, 1'b0, 32'h40);
        done_valid = 1'b0;
        check("R8 same-cycle free", '0, '0);
        finish_op(1);

        // R11/R6: chain in reverse slot order
        issue(3, 1'b1, 32'h10);
        issue(2, 1'b1, 32'h10);
        issue(1, 1'b1, 32'h10);
        check("R11 chain", 4'b0000, 4'b0110);
        finish_op(3);
        check("R11 chain after head", 4'b0000, 4'b0010);
        finish_op(2);
        check("R11 chain tail free", '0, '0);
        finish_op(1);

        // R1: reset mid-traffic
        issue(0, 1'b1, 32'h20);
        issue(1, 1'b0, 32'h20);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears", '0, '0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule